// File: doc/BRIEF.md
# Coalescing Register-Write Command Packer

This block turns a stream of register-write requests into a packed instruction list in a word-addressed buffer RAM, laid out for a command DMA engine that later replays the list. Each request has a 20-bit register offset, a 32-bit value and a mode bit. In direct mode the request becomes a two-word instruction. In indexed mode it opens a burst made of a count word, a header word and the value. A later indexed request to the same register extends that burst in place. The block appends the value and rewrites the count word of the open burst, so no new header is spent.

Instructions start on even word indices. Zero pad words keep the layout aligned when a burst ends on an odd index. A flush request zero-fills the buffer up to the next 64-byte boundary and reports the tail in bytes. After a flush the next list starts again at word 0. A request that arrives when the buffer is full is dropped, and a sticky overflow flag is raised. The buffer RAM sits outside the block and is written one word per cycle.

Top module: `regwr_packer`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_we`, `overflow` and `tail_valid` are 0.
- R2: A direct request (`req_indexed`=0) at free position F writes the value to word F and then the header to word F+1. The header is 0x01 in bits 31:24, 0xF in bits 23:20 and the offset in bits 19:0. The free position becomes F+2 and no alignment is applied.
- R3: An indexed request that does not extend the open burst rounds F up to an even index A. It then writes, in order, count 1 to word A, a header (0x09 in bits 31:24, 0 in bits 23:20, offset in bits 19:0) to A+1, the value to A+2 and a zero pad to A+3. The free position becomes A+3 and the burst start becomes A.
- R4: An indexed request whose offset equals that of the open burst writes, in order, the value to word F and the incremented count to the burst start word. When F+1 is odd, it then writes a zero pad to word F+1. The free position becomes F+1.
- R5: A burst is extended only if the instruction written just before it was an indexed burst with the same offset and no flush came in between. A direct write, a different offset or a flush always starts a new burst.
- R6: Words are written one per cycle on consecutive cycles. After an accepted request that writes N words (counting suppressed ones), `req_ready` stays low for exactly N cycles.
- R7: A request accepted while the free position is at or beyond `CAP_WORDS` writes nothing and leaves `req_ready` high. It sets `overflow`, which stays 1 until a flush completes.
- R8: A flush zero-fills words from the free position up to T-1, where T is the free position rounded up to a multiple of 16. It then pulses `tail_valid` for one cycle with `tail_bytes` = 4*T. It resets the free position and the burst start to 0 and clears `overflow`.
- R9: When `flush` and a request arrive together at an idle block, the flush goes first and `req_ready` is low. The pending request is accepted after the flush completes and lands at word 0.
- R10: No write is issued for a word index at or beyond `CAP_WORDS`. This covers instruction words and flush fill alike, and the position bookkeeping advances anyway.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on a cycle with req_valid high |
| req_indexed | input | 1 | 1 = indexed (burst) write, 0 = direct write |
| req_offset | input | 20 | Register offset |
| req_data | input | 32 | Register value |
| flush | input | 1 | Pad and close the list; taken when the block is idle |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | $clog2(CAP_WORDS) | Buffer word index |
| mem_wdata | output | 32 | Buffer write data |
| overflow | output | 1 | Sticky: a request was dropped because the buffer was full |
| tail_valid | output | 1 | One-cycle pulse at flush completion |
| tail_bytes | output | $clog2(CAP_WORDS)+4 | Byte tail of the flushed list |

## Verification
A flush and a new request can land in the same idle cycle. In that case the block has to order the zero-fill of the old list before the first word of the new one. The bench raises both in one cycle while the free position is unaligned. It checks that `req_ready` is low in that cycle. Through its in-order scoreboard of buffer writes, it then checks that every fill word comes before the request's words, which must appear at indices 0 and 1.

// File: rtl/regwr_packer_pkg.sv
package regwr_packer_pkg;
  localparam logic [7:0] OPC_DIRECT  = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;
  localparam logic [3:0] BE_ALL      = 4'hF;
  localparam int         SLOTS       = 4;
  localparam int         ALIGN_WORDS = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_EMIT, ST_FILL} emit_state_t;

  function automatic logic [31:0] direct_header(input logic [19:0] off);
    return {OPC_DIRECT, BE_ALL, off};
  endfunction

  function automatic logic [31:0] indexed_header(input logic [19:0] off);
    return {OPC_INDEXED, 4'h0, off};
  endfunction
endpackage

// File: rtl/regwr_planner.sv
module regwr_planner
  import regwr_packer_pkg::*;
#(
  parameter int PW = 13
) (
  input  logic                  req_indexed,
  input  logic [19:0]           req_offset,
  input  logic [31:0]           req_data,
  input  logic [PW-1:0]         free_pos,
  input  logic [PW-1:0]         ins_pos,
  input  logic [PW-1:0]         burst_cnt,
  input  logic                  burst_live,
  input  logic [19:0]           burst_off,
  output logic [2:0]            n_words,
  output logic [SLOTS-1:0][PW-1:0] slot_addr,
  output logic [SLOTS-1:0][31:0]   slot_data,
  output logic [PW-1:0]         nxt_free,
  output logic [PW-1:0]         nxt_ins,
  output logic [PW-1:0]         nxt_cnt,
  output logic                  nxt_live,
  output logic [19:0]           nxt_off
);
  logic [PW-1:0] aligned;
  logic [PW-1:0] bumped;
  logic          extend;

  assign aligned = free_pos + {{(PW-1){1'b0}}, free_pos[0]};
  assign bumped  = burst_cnt + PW'(1);
  assign extend  = req_indexed && burst_live && (req_offset == burst_off);

  always_comb begin
    n_words   = 3'd0;
    slot_addr = '0;
    slot_data = '0;
    nxt_free  = free_pos;
    nxt_ins   = ins_pos;
    nxt_cnt   = burst_cnt;
    nxt_live  = burst_live;
    nxt_off   = burst_off;
    if (!req_indexed) begin
      slot_addr[0] = free_pos;
      slot_data[0] = req_data;
      slot_addr[1] = free_pos + PW'(1);
      slot_data[1] = direct_header(req_offset);
      n_words      = 3'd2;
      nxt_ins      = free_pos;
      nxt_free     = free_pos + PW'(2);
      nxt_live     = 1'b0;
    end else if (extend) begin
      slot_addr[0] = free_pos;
      slot_data[0] = req_data;
      slot_addr[1] = ins_pos;
      slot_data[1] = 32'(bumped);
      n_words      = 3'd2;
      nxt_free     = free_pos + PW'(1);
      nxt_cnt      = bumped;
      if (!free_pos[0]) begin
        slot_addr[2] = free_pos + PW'(1);
        slot_data[2] = 32'd0;
        n_words      = 3'd3;
      end
    end else begin
      slot_addr[0] = aligned;
      slot_data[0] = 32'd1;
      slot_addr[1] = aligned + PW'(1);
      slot_data[1] = indexed_header(req_offset);
      slot_addr[2] = aligned + PW'(2);
      slot_data[2] = req_data;
      slot_addr[3] = aligned + PW'(3);
      slot_data[3] = 32'd0;
      n_words      = 3'd4;
      nxt_ins      = aligned;
      nxt_free     = aligned + PW'(3);
      nxt_cnt      = PW'(1);
      nxt_live     = 1'b1;
      nxt_off      = req_offset;
    end
  end
endmodule

// File: rtl/regwr_emitter.sv
module regwr_emitter
  import regwr_packer_pkg::*;
#(
  parameter int CAP_WORDS = 2048,
  parameter int AW        = 11,
  parameter int PW        = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [2:0]               n_words,
  input  logic [SLOTS-1:0][PW-1:0] slot_addr,
  input  logic [SLOTS-1:0][31:0]   slot_data,
  input  logic                     fill_start,
  input  logic [PW-1:0]            fill_from,
  input  logic [PW-1:0]            fill_to,
  output logic                     busy,
  output logic                     fill_done,
  output logic                     mem_we,
  output logic [AW-1:0]            mem_addr,
  output logic [31:0]              mem_wdata
);
  localparam logic [PW-1:0] CAP_P = PW'(CAP_WORDS);

  emit_state_t             st;
  logic [SLOTS-1:0][PW-1:0] held_addr;
  logic [SLOTS-1:0][31:0]   held_data;
  logic [2:0]              held_n;
  logic [1:0]              idx;
  logic [PW-1:0]           ptr;
  logic [PW-1:0]           lim;
  logic [PW-1:0]           cur_addr;

  assign busy      = (st != ST_IDLE);
  assign fill_done = (st == ST_FILL) && (ptr == lim);
  assign cur_addr  = held_addr[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      held_addr <= '0;
      held_data <= '0;
      held_n    <= 3'd0;
      idx       <= 2'd0;
      ptr       <= '0;
      lim       <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (load && n_words != 3'd0) begin
            held_addr <= slot_addr;
            held_data <= slot_data;
            held_n    <= n_words;
            idx       <= 2'd0;
            st        <= ST_EMIT;
          end else if (fill_start) begin
            ptr <= fill_from;
            lim <= fill_to;
            st  <= ST_FILL;
          end
        end
        ST_EMIT: begin
          mem_we    <= (cur_addr < CAP_P);
          mem_addr  <= cur_addr[AW-1:0];
          mem_wdata <= held_data[idx];
          idx       <= idx + 2'd1;
          if ({1'b0, idx} == held_n - 3'd1) st <= ST_IDLE;
        end
        ST_FILL: begin
          if (ptr != lim) begin
            mem_we    <= (ptr < CAP_P);
            mem_addr  <= ptr[AW-1:0];
            mem_wdata <= 32'd0;
            ptr       <= ptr + PW'(1);
          end else begin
            st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_EMIT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EMIT && cur_addr < CAP_P) |=> mem_we); // R6
endmodule

// File: rtl/regwr_packer.sv
module regwr_packer
  import regwr_packer_pkg::*;
#(
  parameter int CAP_WORDS = 2048,
  localparam int AW = $clog2(CAP_WORDS),
  localparam int PW = AW + 2,
  localparam int TW = PW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_indexed,
  input  logic [19:0]   req_offset,
  input  logic [31:0]   req_data,
  input  logic          flush,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic          overflow,
  output logic          tail_valid,
  output logic [TW-1:0] tail_bytes
);
  localparam logic [PW-1:0] CAP_P  = PW'(CAP_WORDS);
  localparam logic [PW-1:0] ALN_M1 = PW'(ALIGN_WORDS - 1);

  logic [PW-1:0] free_pos, ins_pos, burst_cnt;
  logic          burst_live;
  logic [19:0]   burst_off;

  logic [2:0]               n_words;
  logic [SLOTS-1:0][PW-1:0] slot_addr;
  logic [SLOTS-1:0][31:0]   slot_data;
  logic [PW-1:0] nxt_free, nxt_ins, nxt_cnt;
  logic          nxt_live;
  logic [19:0]   nxt_off;

  logic          busy, fill_done;
  logic          accept, full, take, flush_go;
  logic [PW-1:0] tail_words;
  logic [PW-1:0] tail_hold;

  assign req_ready  = !busy && !flush;
  assign accept     = req_valid && req_ready;
  assign full       = (free_pos >= CAP_P);
  assign take       = accept && !full;
  assign flush_go   = flush && !busy;
  assign tail_words = (free_pos + ALN_M1) & ~ALN_M1;

  regwr_planner #(.PW(PW)) u_plan (
    .req_indexed(req_indexed), .req_offset(req_offset), .req_data(req_data),
    .free_pos(free_pos), .ins_pos(ins_pos), .burst_cnt(burst_cnt),
    .burst_live(burst_live), .burst_off(burst_off),
    .n_words(n_words), .slot_addr(slot_addr), .slot_data(slot_data),
    .nxt_free(nxt_free), .nxt_ins(nxt_ins), .nxt_cnt(nxt_cnt),
    .nxt_live(nxt_live), .nxt_off(nxt_off)
  );

  regwr_emitter #(.CAP_WORDS(CAP_WORDS), .AW(AW), .PW(PW)) u_emit (
    .clk(clk), .rst(rst), .load(take), .n_words(n_words),
    .slot_addr(slot_addr), .slot_data(slot_data),
    .fill_start(flush_go), .fill_from(free_pos), .fill_to(tail_words),
    .busy(busy), .fill_done(fill_done),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      free_pos   <= '0;
      ins_pos    <= '0;
      burst_cnt  <= '0;
      burst_live <= 1'b0;
      burst_off  <= '0;
      overflow   <= 1'b0;
      tail_valid <= 1'b0;
      tail_bytes <= '0;
      tail_hold  <= '0;
    end else begin
      tail_valid <= 1'b0;
      if (flush_go) tail_hold <= tail_words;
      if (accept && full) overflow <= 1'b1;
      if (take) begin
        free_pos   <= nxt_free;
        ins_pos    <= nxt_ins;
        burst_cnt  <= nxt_cnt;
        burst_live <= nxt_live;
        burst_off  <= nxt_off;
      end
      if (fill_done) begin
        free_pos   <= '0;
        ins_pos    <= '0;
        burst_cnt  <= '0;
        burst_live <= 1'b0;
        overflow   <= 1'b0;
        tail_valid <= 1'b1;
        tail_bytes <= {tail_hold, 2'b00};
      end
    end
  end

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
    take |=> !req_ready); // R6
  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (accept && full) |=> !mem_we); // R7
  AST_OVF_CLEARS_AT_TAIL: assert property (@(posedge clk) disable iff (rst)
    $fell(overflow) |-> tail_valid); // R7
  AST_TAIL_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    tail_valid |-> (tail_bytes[5:0] == 6'd0)); // R8
  AST_TAIL_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    tail_valid |=> !tail_valid); // R8
  AST_FLUSH_FIRST: assert property (@(posedge clk) disable iff (rst)
    flush_go |=> !req_ready); // R9
endmodule

// File: tb/tb_regwr_packer.sv
module tb_regwr_packer;
  localparam int CAP = 64;
  localparam int AW  = $clog2(CAP);
  localparam int TW  = AW + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_indexed = 1'b0, flush = 1'b0;
  logic [19:0] req_offset = '0;
  logic [31:0] req_data = '0;
  logic req_ready, mem_we, overflow, tail_valid;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [TW-1:0] tail_bytes;

  always #2 clk = ~clk;

  regwr_packer #(.CAP_WORDS(CAP)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_indexed(req_indexed), .req_offset(req_offset), .req_data(req_data),
    .flush(flush), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .overflow(overflow), .tail_valid(tail_valid), .tail_bytes(tail_bytes)
  );

  typedef struct { int addr; logic [31:0] data; string tag; } wr_t;
  wr_t exp_w[$];
  int  exp_t[$];
  int  n_checks = 0, n_fail = 0;
  bit  finished = 0;

  int m_free = 0, m_ins = 0, m_cnt = 0;
  bit m_live = 0;
  logic [19:0] m_off = '0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void expect_w(input int a, input logic [31:0] d, input string tag);
    if (a < CAP) exp_w.push_back('{a, d, tag}); // R10: out-of-range words never appear
  endfunction

  function automatic void model_req(input bit ix, input logic [19:0] off, input logic [31:0] d,
                                    input string tag, output int n, output bit drop);
    n = 0;
    drop = (m_free >= CAP);
    if (drop) return;
    if (!ix) begin
      expect_w(m_free, d, tag);
      expect_w(m_free + 1, {8'h01, 4'hF, off}, tag);
      m_ins = m_free; m_free += 2; m_live = 0; n = 2;
    end else if (m_live && off == m_off) begin
      m_cnt++;
      expect_w(m_free, d, tag);
      expect_w(m_ins, m_cnt, tag);
      n = 2;
      if (m_free % 2 == 0) begin expect_w(m_free + 1, 0, tag); n = 3; end
      m_free++;
    end else begin
      int a;
      a = m_free + (m_free % 2);
      expect_w(a, 1, tag);
      expect_w(a + 1, {8'h09, 4'h0, off}, tag);
      expect_w(a + 2, d, tag);
      expect_w(a + 3, 0, tag);
      m_ins = a; m_free = a + 3; m_cnt = 1; m_live = 1; m_off = off; n = 4;
    end
  endfunction

  function automatic void model_flush(input string tag);
    int t;
    t = ((m_free + 15) / 16) * 16;
    for (int a = m_free; a < t; a++) expect_w(a, 0, tag);
    exp_t.push_back(t * 4);
    m_free = 0; m_ins = 0; m_live = 0; m_cnt = 0;
  endfunction

  task automatic drive_req(input bit ix, input logic [19:0] off, input logic [31:0] d, input string tag);
    int n, lowc;
    bit drop;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model_req(ix, off, d, tag, n, drop);
    req_indexed = ix; req_offset = off; req_data = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lowc = 0;
    if (drop) check(overflow == 1'b1, "R7 overflow set on drop", overflow, 1);
    while (!req_ready) begin lowc++; @(negedge clk); end
    check(lowc == n, "R6 ready-low cycles", lowc, n);
  endtask

  task automatic do_flush(input string tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model_flush(tag);
    flush = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flush = 1'b0;
    while (!req_ready) @(negedge clk);
    check(overflow == 1'b0, "R8 overflow cleared by flush", overflow, 0);
  endtask

  // monitor: compares writes and tails in order against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        if (exp_w.size() == 0) begin
          check(1'b0, "R6 unexpected write", int'(mem_addr), -1);
        end else begin
          wr_t e;
          e = exp_w.pop_front();
          check(int'(mem_addr) == e.addr, {e.tag, " write address"}, int'(mem_addr), e.addr);
          check(mem_wdata == e.data, {e.tag, " write data"}, int'(mem_wdata), int'(e.data));
        end
      end
      if (tail_valid) begin
        if (exp_t.size() == 0) begin
          check(1'b0, "R8 unexpected tail", int'(tail_bytes), -1);
        end else begin
          int et;
          et = exp_t.pop_front();
          check(int'(tail_bytes) == et, "R8 tail bytes", int'(tail_bytes), et);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(mem_we == 1'b0, "R1 no write", mem_we, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    check(tail_valid == 1'b0, "R1 tail_valid", tail_valid, 0);

    drive_req(1'b0, 20'h12345, 32'hA0A0_0001, "R2");
    drive_req(1'b1, 20'h00400, 32'hB0B0_0002, "R3");
    drive_req(1'b1, 20'h00400, 32'hC0C0_0003, "R4");
    drive_req(1'b1, 20'h00400, 32'hD0D0_0004, "R4");
    drive_req(1'b0, 20'h00400, 32'hE0E0_0005, "R2");
    drive_req(1'b1, 20'h00400, 32'hF0F0_0006, "R5");
    drive_req(1'b1, 20'h00500, 32'h1111_0007, "R5");
    do_flush("R8");
    drive_req(1'b1, 20'h00500, 32'h2222_0008, "R5");

    // R9: flush and request in the same idle cycle
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    model_flush("R9");
    begin
      int n; bit drop;
      model_req(1'b0, 20'h0ABCD, 32'h3333_0009, "R9", n, drop);
    end
    flush = 1'b1;
    req_indexed = 1'b0; req_offset = 20'h0ABCD; req_data = 32'h3333_0009; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b0, "R9 request held during flush", req_ready, 0);
    flush = 1'b0;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);

    do_flush("R8");
    do_flush("R8");

    // R7 / R10: fill to the top, spill past capacity, then overflow
    for (int i = 0; i < 31; i++) drive_req(1'b0, 20'(i), 32'h4000_0000 + i, "R2");
    drive_req(1'b1, 20'h00777, 32'h5555_000A, "R10");
    drive_req(1'b0, 20'h00001, 32'h6666_000B, "R7");
    drive_req(1'b1, 20'h00777, 32'h7777_000C, "R7");
    check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
    do_flush("R10");
    drive_req(1'b0, 20'h00042, 32'h8888_000D, "R8");

    repeat (10) @(negedge clk);
    check(exp_w.size() == 0, "R6 all expected writes seen", exp_w.size(), 0);
    check(exp_t.size() == 0, "R8 all expected tails seen", exp_t.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule